// File: doc/BRIEF.md
# Clock Recovery Loop Controller

This block closes the software-style loop that locks a local 27 MHz time base to the clock references carried in a transport stream. Each time a clock reference arrives, the block takes the latched reference and the local time counter in their split form: a coarse 32-bit word and a 10-bit extension word. It turns both into linear tick counts. It then rejects samples whose coarse upper fields disagree or that come with an overflow flag. From the accepted samples it computes a correction made of a rate term and an offset term. It limits that correction and applies it to a signed 12-bit oscillator steering word. The result never wraps past either end of the signed range.

A small state machine sequences the work. `S_IDLE` accepts a strobe and goes to `S_CHECK`. `S_CHECK` goes back to `S_IDLE` on an error sample or a first (reference-only) sample. It goes to `S_DIVIDE` when the reference delta is positive, and to `S_COMBINE` otherwise. `S_DIVIDE` goes to `S_COMBINE` when the sequential divider finishes. `S_COMBINE` goes to `S_WRITE`, and `S_WRITE` goes back to `S_IDLE` while issuing the steering-word write. Besides the steering word, the block keeps an error counter, raises a one-cycle reload request after two errors in a row, and maintains a threshold value that it switches between zero and a high setting.

Top module: `clkrec_loop`

## Requirements
- R1: A timestamp is converted as ((coarse[21:0] × 2 + ext[9]) × 300) + ext[8:0]. Coarse bits [31:22] form the era field.
- R2: A sample is an error when `hw_ovf` is high or the era fields of the reference and the local counter differ. An error sample adds one to `err_count` (wrapping) and produces no `pwm_we`.
- R3: A second error sample that directly follows an error sample pulses `pid_reload` for one cycle and clears the consecutive-error flag, so a third error does not pulse. Any good sample also clears the flag.
- R4: The rate term is ((ΔPCR − ΔSTC) × floor(27,000,000 / ΔPCR)) arithmetically shifted right by RATE_GAIN (8). The deltas are taken against the last good sample. When ΔPCR ≤ 0 the rate term is 0.
- R5: The offset term is (PCR − STC) arithmetically shifted right by DELTA_GAIN (4). The raw adjustment is rate term + offset term.
- R6: An accepted strobe increments a reference counter only while the counter is ≤ HG_LIMIT (4). While the counter, after that step, is ≤ HG_LIMIT, the adjustment is clamped to ±LOAD_CLAMP (64). Afterwards it is clamped to ±STEADY_CLAMP (8).
- R7: `pwm_new` is `pwm_cur` (signed 12-bit) plus the adjustment. A sum above 0x7FF gives 0x7FF, and a sum below 0x800 (−2048) gives 0x800. Otherwise the sum is written as is, including crossings of zero (for example 0x002 − 8 = 0xFFA).
- R8: On a good non-first sample, if |PCR − STC| and the stored previous delta are both < LOW_THR (100), `thresh_val` becomes HIGH_THR (1000) and `thresh_we` pulses. Otherwise, if `thresh_val` is nonzero, it becomes 0 and `thresh_we` pulses.
- R9: Every good sample stores its PCR, STC and |PCR − STC| as the references. The first good sample after reset only stores them and issues no `pwm_we` and no threshold change. Error samples leave the references unchanged.
- R10: `busy` is high from the cycle after an accepted strobe until the last processing cycle, which includes the `pwm_we` cycle. A strobe seen while `busy` is high is ignored.
- R11: After reset, `pwm_we`, `pid_reload`, `thresh_we` and `busy` are low, and `err_count` and `thresh_val` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcr_strobe | input | 1 | A new clock reference sample is present |
| pcr_base | input | 32 | Coarse word of the received reference |
| pcr_ext | input | 10 | Extension word of the received reference |
| stc_base | input | 32 | Coarse word of the local time counter |
| stc_ext | input | 10 | Extension word of the local time counter |
| hw_ovf | input | 1 | Counter overflow flag; the sample counts as an error |
| pwm_cur | input | 12 | Current signed steering word |
| pwm_new | output | 12 | Updated steering word, valid with `pwm_we` |
| pwm_we | output | 1 | One-cycle write strobe for `pwm_new` |
| pid_reload | output | 1 | One-cycle request to reload the reference source |
| err_count | output | 16 | Wrapping count of error samples |
| thresh_val | output | 10 | Current threshold setting |
| thresh_we | output | 1 | One-cycle strobe when `thresh_val` is rewritten |
| busy | output | 1 | A sample is being processed; strobes are ignored |

## Verification
The bench builds the block with its default parameters: gains of 8 and 4, clamps of 64 and 8, a high-gain window of four references, and thresholds of 100 and 1000. With a four-reference window, the switch from the wide clamp to the narrow one happens by the fifth strobe. The narrow clamp of 8 then lets a steering word set a few counts from either end push past that end, which checks both saturation cases and a crossing of zero in three samples. The small low threshold allows a single pair of near-aligned samples to set the high threshold and a single misaligned one to clear it. A nominal spacing of 4500 coarse units keeps the divider quotient at 10, which makes the rate term easy to follow.

// File: rtl/clkrec_pkg.sv
package clkrec_pkg;

    // Width of a normalized timestamp: 23-bit base times 300 plus 9 bits
    localparam int TS_W = 33;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_DIVIDE,
        S_COMBINE,
        S_WRITE
    } loop_state_t;

endpackage

// File: rtl/clkrec_norm.sv
module clkrec_norm #(
    parameter int TS_W = 33
) (
    input  logic [31:0]     base_word,
    input  logic [9:0]      ext_word,
    output logic [TS_W-1:0] ts,
    output logic [9:0]      era
);

    logic [TS_W-1:0] coarse;

    always_comb begin
        coarse = TS_W'({base_word[21:0], ext_word[9]});
        ts     = coarse * TS_W'(300) + TS_W'(ext_word[8:0]);
        era    = base_word[31:22];
    end

endmodule

// File: rtl/clkrec_div.sv
module clkrec_div #(
    parameter int DIVIDEND = 27_000_000,
    parameter int DIV_W    = 33,
    localparam int QW      = $clog2(DIVIDEND + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] divisor,
    output logic             done,
    output logic [QW-1:0]    quot
);

    localparam int CW = $clog2(QW + 1);

    logic [DIV_W-1:0] dvs;
    logic [DIV_W-1:0] rem;
    logic [CW-1:0]    left;
    logic             run;
    logic [DIV_W:0]   trial;

    assign trial = {rem, quot[QW-1]};

    // Restoring division: the dividend is shifted out of quot while
    // quotient bits are shifted in, one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvs  <= '0;
            rem  <= '0;
            quot <= '0;
            left <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                dvs  <= divisor;
                rem  <= '0;
                quot <= QW'(DIVIDEND);
                left <= CW'(QW);
                run  <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, dvs}) begin
                    rem  <= DIV_W'(trial - {1'b0, dvs});
                    quot <= {quot[QW-2:0], 1'b1};
                end else begin
                    rem  <= trial[DIV_W-1:0];
                    quot <= {quot[QW-2:0], 1'b0};
                end
                left <= left - 1'b1;
                if (left == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dvs != '0) |->
            ((64'(quot) * 64'(dvs) <= 64'(DIVIDEND)) &&
             (64'(DIVIDEND) - 64'(quot) * 64'(dvs) < 64'(dvs)))); // R4

endmodule

// File: rtl/clkrec_sat.sv
module clkrec_sat #(
    parameter int PWM_W = 12,
    parameter int AW    = 8
) (
    input  logic [PWM_W-1:0]     pwm_old,
    input  logic signed [AW-1:0] adj,
    output logic [PWM_W-1:0]     pwm_out
);

    localparam int SW = ((AW > PWM_W) ? AW : PWM_W) + 2;
    localparam logic signed [SW-1:0] TOP_V = SW'((2 ** (PWM_W - 1)) - 1);
    localparam logic signed [SW-1:0] BOT_V = -SW'(2 ** (PWM_W - 1));

    logic signed [SW-1:0] sum;

    always_comb begin
        sum = $signed({{(SW - PWM_W){pwm_old[PWM_W-1]}}, pwm_old})
            + $signed({{(SW - AW){adj[AW-1]}}, adj});
        if (sum > TOP_V) begin
            pwm_out = {1'b0, {(PWM_W - 1){1'b1}}};
        end else if (sum < BOT_V) begin
            pwm_out = {1'b1, {(PWM_W - 1){1'b0}}};
        end else begin
            pwm_out = sum[PWM_W-1:0];
        end
    end

endmodule

// File: rtl/clkrec_loop.sv
module clkrec_loop
    import clkrec_pkg::*;
#(
    parameter int RATE_GAIN    = 8,
    parameter int DELTA_GAIN   = 4,
    parameter int LOAD_CLAMP   = 64,
    parameter int STEADY_CLAMP = 8,
    parameter int HG_LIMIT     = 4,
    parameter int LOW_THR      = 100,
    parameter int HIGH_THR     = 1000,
    parameter int CLK_HZ       = 27_000_000,
    parameter int PWM_W        = 12,
    parameter int ERR_W        = 16,
    localparam int THR_W       = $clog2(HIGH_THR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pcr_strobe,
    input  logic [31:0]      pcr_base,
    input  logic [9:0]       pcr_ext,
    input  logic [31:0]      stc_base,
    input  logic [9:0]       stc_ext,
    input  logic             hw_ovf,
    input  logic [PWM_W-1:0] pwm_cur,
    output logic [PWM_W-1:0] pwm_new,
    output logic             pwm_we,
    output logic             pid_reload,
    output logic [ERR_W-1:0] err_count,
    output logic [THR_W-1:0] thresh_val,
    output logic             thresh_we,
    output logic             busy
);

    localparam int DW = TS_W + 1;                      // signed difference width
    localparam int NW = $clog2(HG_LIMIT + 2);          // reference counter width
    localparam int AW = $clog2(LOAD_CLAMP + 1) + 2;    // clamped adjustment width
    localparam int QW = $clog2(CLK_HZ + 1);            // quotient width
    localparam logic signed [AW-1:0] LIM_LD = AW'(LOAD_CLAMP);
    localparam logic signed [AW-1:0] LIM_ST = AW'(STEADY_CLAMP);

    loop_state_t state, state_nx;

    // latched sample
    logic [31:0] lat_pb, lat_sb;
    logic [9:0]  lat_pe, lat_se;
    logic        lat_ovf;

    // loop memory
    logic [TS_W-1:0] ref_pcr, ref_stc, ref_delta;
    logic            have_ref;
    logic            prev_err;
    logic [NW-1:0]   npcrs;

    // per-sample working registers
    logic signed [DW-1:0] dp_q, ds_q, off_q;
    logic                 use_q;
    logic signed [AW-1:0] adj_q;

    // normalization
    logic [31:0]     nb   [2];
    logic [9:0]      ne   [2];
    logic [TS_W-1:0] nts  [2];
    logic [9:0]      nera [2];

    assign nb[0] = lat_pb;
    assign ne[0] = lat_pe;
    assign nb[1] = lat_sb;
    assign ne[1] = lat_se;

    for (genvar gi = 0; gi < 2; gi++) begin : g_norm
        clkrec_norm #(.TS_W(TS_W)) u_norm (
            .base_word (nb[gi]),
            .ext_word  (ne[gi]),
            .ts        (nts[gi]),
            .era       (nera[gi])
        );
    end

    // sample classification and differences
    logic                 sample_bad;
    logic signed [DW-1:0] cur_off, cur_dp, cur_ds;
    logic [TS_W-1:0]      cur_abs;
    logic                 dp_pos;
    logic                 small_now, small_prev;
    logic                 in_window;

    always_comb begin
        sample_bad = lat_ovf || (nera[0] != nera[1]);
        cur_off    = $signed({1'b0, nts[0]}) - $signed({1'b0, nts[1]});
        cur_dp     = $signed({1'b0, nts[0]}) - $signed({1'b0, ref_pcr});
        cur_ds     = $signed({1'b0, nts[1]}) - $signed({1'b0, ref_stc});
        cur_abs    = cur_off[DW-1] ? TS_W'(-cur_off) : TS_W'(cur_off);
        dp_pos     = !cur_dp[DW-1] && (cur_dp != '0);
        small_now  = cur_abs < TS_W'(LOW_THR);
        small_prev = ref_delta < TS_W'(LOW_THR);
        in_window  = npcrs <= NW'(HG_LIMIT);
    end

    // divider for the rate quotient
    logic          div_start;
    logic          div_done;
    logic [QW-1:0] div_q;

    assign div_start = (state == S_CHECK) && !sample_bad && have_ref && dp_pos;

    clkrec_div #(.DIVIDEND(CLK_HZ), .DIV_W(TS_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (div_start),
        .divisor (cur_dp[TS_W-1:0]),
        .done    (div_done),
        .quot    (div_q)
    );

    // rate plus offset, then clamp
    logic signed [63:0]   d64, q64, prod, rate64, off64, raw64, lim64;
    logic signed [AW-1:0] adj_c;

    always_comb begin
        d64    = $signed({{(64 - DW){dp_q[DW-1]}}, dp_q})
               - $signed({{(64 - DW){ds_q[DW-1]}}, ds_q});
        q64    = use_q ? $signed({{(64 - QW){1'b0}}, div_q}) : 64'sd0;
        prod   = d64 * q64;
        rate64 = prod >>> RATE_GAIN;
        off64  = $signed({{(64 - DW){off_q[DW-1]}}, off_q}) >>> DELTA_GAIN;
        raw64  = rate64 + off64;
        lim64  = in_window ? 64'(LOAD_CLAMP) : 64'(STEADY_CLAMP);
        if (raw64 > lim64) begin
            adj_c = AW'(lim64);
        end else if (raw64 < -lim64) begin
            adj_c = AW'(-lim64);
        end else begin
            adj_c = AW'(raw64);
        end
    end

    logic [PWM_W-1:0] sat_out;

    clkrec_sat #(.PWM_W(PWM_W), .AW(AW)) u_sat (
        .pwm_old (pwm_cur),
        .adj     (adj_q),
        .pwm_out (sat_out)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (pcr_strobe) state_nx = S_CHECK;
            S_CHECK: begin
                if (sample_bad || !have_ref) state_nx = S_IDLE;
                else if (dp_pos)             state_nx = S_DIVIDE;
                else                         state_nx = S_COMBINE;
            end
            S_DIVIDE:  if (div_done) state_nx = S_COMBINE;
            S_COMBINE: state_nx = S_WRITE;
            S_WRITE:   state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_pb     <= '0;
            lat_pe     <= '0;
            lat_sb     <= '0;
            lat_se     <= '0;
            lat_ovf    <= 1'b0;
            ref_pcr    <= '0;
            ref_stc    <= '0;
            ref_delta  <= '0;
            have_ref   <= 1'b0;
            prev_err   <= 1'b0;
            npcrs      <= '0;
            dp_q       <= '0;
            ds_q       <= '0;
            off_q      <= '0;
            use_q      <= 1'b0;
            adj_q      <= '0;
            err_count  <= '0;
            pid_reload <= 1'b0;
            thresh_val <= '0;
            thresh_we  <= 1'b0;
        end else begin
            pid_reload <= 1'b0;
            thresh_we  <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (pcr_strobe) begin
                        lat_pb  <= pcr_base;
                        lat_pe  <= pcr_ext;
                        lat_sb  <= stc_base;
                        lat_se  <= stc_ext;
                        lat_ovf <= hw_ovf;
                        if (in_window) npcrs <= npcrs + 1'b1;
                    end
                end
                S_CHECK: begin
                    if (sample_bad) begin
                        err_count  <= err_count + 1'b1;
                        pid_reload <= prev_err;
                        prev_err   <= !prev_err;
                    end else begin
                        prev_err <= 1'b0;
                        if (have_ref) begin
                            dp_q  <= cur_dp;
                            ds_q  <= cur_ds;
                            off_q <= cur_off;
                            use_q <= dp_pos;
                            if (small_now && small_prev) begin
                                thresh_val <= THR_W'(HIGH_THR);
                                thresh_we  <= 1'b1;
                            end else if (thresh_val != '0) begin
                                thresh_val <= '0;
                                thresh_we  <= 1'b1;
                            end
                        end
                        ref_pcr   <= nts[0];
                        ref_stc   <= nts[1];
                        ref_delta <= cur_abs;
                        have_ref  <= 1'b1;
                    end
                end
                S_COMBINE: adj_q <= adj_c;
                S_DIVIDE, S_WRITE: ;
                default: ;
            endcase
        end
    end

    // combinational outputs
    always_comb begin
        pwm_we  = (state == S_WRITE);
        pwm_new = sat_out;
        busy    = (state != S_IDLE);
    end

    AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_count) |-> err_count == ERR_W'($past(err_count) + 1'b1)); // R2
    AST_RELOAD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        pid_reload |-> err_count != $past(err_count)); // R3
    AST_CLAMP_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_we |-> (adj_q <= LIM_LD && adj_q >= -LIM_LD)); // R6
    AST_CLAMP_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_we && !in_window) |-> (adj_q <= LIM_ST && adj_q >= -LIM_ST)); // R6
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_we && !pwm_cur[PWM_W-1] && adj_q > 0) |-> !pwm_new[PWM_W-1]); // R7
    AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_we && pwm_cur[PWM_W-1] && adj_q < 0) |-> pwm_new[PWM_W-1]); // R7
    AST_THR_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        thresh_we |-> (thresh_val == '0 || thresh_val == THR_W'(HIGH_THR))); // R8
    AST_IDLE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_we |=> !busy); // R10

endmodule

// File: tb/sim_clkrec_loop.sv
`timescale 1ns/1ps
module sim_clkrec_loop;

    localparam int HG   = 4;
    localparam int LDC  = 64;
    localparam int STC_ = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pcr_strobe = 1'b0;
    logic [31:0] pcr_base = '0, stc_base = '0;
    logic [9:0]  pcr_ext = '0, stc_ext = '0;
    logic        hw_ovf = 1'b0;
    logic [11:0] pwm_cur = '0;
    logic [11:0] pwm_new;
    logic        pwm_we, pid_reload, thresh_we, busy;
    logic [15:0] err_count;
    logic [9:0]  thresh_val;

    always #2.5 clk = ~clk;

    clkrec_loop u0 (
        .clk(clk), .rst_n(rst_n), .pcr_strobe(pcr_strobe),
        .pcr_base(pcr_base), .pcr_ext(pcr_ext),
        .stc_base(stc_base), .stc_ext(stc_ext),
        .hw_ovf(hw_ovf), .pwm_cur(pwm_cur),
        .pwm_new(pwm_new), .pwm_we(pwm_we), .pid_reload(pid_reload),
        .err_count(err_count), .thresh_val(thresh_val),
        .thresh_we(thresh_we), .busy(busy)
    );

    int n_chk = 0, n_fail = 0;
    logic [11:0] exp_q[$];
    int reload_seen = 0, thrwe_seen = 0;
    bit finished = 1'b0;

    // reference model state
    int     m_np = 0;
    bit     m_have = 0, m_perr = 0;
    longint m_rp = 0, m_rs = 0, m_pd = 0;
    int     m_err = 0, m_thr = 0, m_reload = 0, m_thrwe = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic longint nrm(input logic [31:0] b, input logic [9:0] e);
        return ((longint'(b[21:0]) * 2 + longint'(e[9])) * 300) + longint'(e[8:0]);
    endfunction

    // monitor: pops expected steering words as writes appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (pid_reload) reload_seen++;
            if (thresh_we) thrwe_seen++;
            if (pwm_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected write", longint'(pwm_new), -1);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    check(pwm_new == e, "R5 R6 R7 pwm_new", longint'(pwm_new), longint'(e));
                end
            end
        end
    end

    // driver: updates the model, pushes expectations, drives one strobe
    task automatic sample(input logic [31:0] pb, input logic [9:0] pe,
                          input logic [31:0] sb, input logic [9:0] se,
                          input bit ovf, input bit poke);
        bit err;
        longint p, s, d, dp, ds, q, adj, lim, sv;
        if (m_np <= HG) m_np++;
        err = ovf || (pb[31:22] != sb[31:22]);
        if (err) begin
            m_err = (m_err + 1) % 65536;
            if (m_perr) begin m_reload++; m_perr = 0; end
            else m_perr = 1;
        end else begin
            m_perr = 0;
            p = nrm(pb, pe);
            s = nrm(sb, se);
            d = (p > s) ? p - s : s - p;
            if (!m_have) begin
                m_have = 1;
            end else begin
                dp  = p - m_rp;
                ds  = s - m_rs;
                q   = (dp > 0) ? 27000000 / dp : 0;
                adj = (((dp - ds) * q) >>> 8) + ((p - s) >>> 4);
                lim = (m_np <= HG) ? LDC : STC_;
                if (adj > lim) adj = lim;
                else if (adj < -lim) adj = -lim;
                if (d < 100 && m_pd < 100) begin m_thr = 1000; m_thrwe++; end
                else if (m_thr != 0) begin m_thr = 0; m_thrwe++; end
                sv = longint'($signed(pwm_cur)) + adj;
                if (sv > 2047) sv = 2047;
                else if (sv < -2048) sv = -2048;
                exp_q.push_back(sv[11:0]);
            end
            m_rp = p;
            m_rs = s;
            m_pd = d;
        end
        @(negedge clk);
        pcr_base = pb; pcr_ext = pe; stc_base = sb; stc_ext = se; hw_ovf = ovf;
        pcr_strobe = 1'b1;
        @(negedge clk);
        pcr_strobe = 1'b0;
        check(busy == 1'b1, "R10 busy after strobe", longint'(busy), 1);
        if (poke) begin
            // a strobe while busy must change nothing
            pcr_base = 32'h00C0_0000; stc_base = 32'h0; hw_ovf = 1'b1;
            pcr_strobe = 1'b1;
            @(negedge clk);
            pcr_strobe = 1'b0;
            hw_ovf = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        check(err_count == 16'(m_err), "R2 err_count", longint'(err_count), longint'(m_err));
        check(reload_seen == m_reload, "R3 reload pulses", reload_seen, m_reload);
        check(thresh_val == 10'(m_thr), "R8 thresh_val", longint'(thresh_val), m_thr);
        check(thrwe_seen == m_thrwe, "R8 thresh_we pulses", thrwe_seen, m_thrwe);
        check(exp_q.size() == 0, "R9 write issued", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R10 watchdog: act=%0d exp=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        check(pwm_we == 0 && busy == 0 && pid_reload == 0 && thresh_we == 0,
              "R11 strobes low in reset", {pwm_we, busy, pid_reload, thresh_we}, 0);
        check(err_count == 0 && thresh_val == 0, "R11 counters zero",
              longint'(err_count) + longint'(thresh_val), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && pwm_we == 0, "R11 idle after reset", {busy, pwm_we}, 0);

        // R9 first sample only stores references
        sample(32'd1000, 10'd0, 32'd1000, 10'd0, 0, 0);
        // R4 R5 R8 small offset, threshold goes high
        pwm_cur = 12'h000;
        sample(32'd5500, 10'd0, 32'd5500, 10'd5, 0, 0);
        // R6 wide clamp with a large lag; threshold cleared
        pwm_cur = 12'h100;
        sample(32'd10000, 10'd0, 32'd9990, 10'd0, 0, 0);
        // R6 negative wide clamp
        pwm_cur = 12'h7F0;
        sample(32'd14500, 10'd0, 32'd14500, 10'd0, 0, 0);
        // R6 R7 narrow clamp, saturation at 0x7FF
        pwm_cur = 12'h7FC;
        sample(32'd19000, 10'd0, 32'd18990, 10'd0, 0, 0);
        // R7 saturation at 0x800
        pwm_cur = 12'h803;
        sample(32'd23500, 10'd0, 32'd23510, 10'd0, 0, 0);
        // R7 crossing zero downwards
        pwm_cur = 12'h002;
        sample(32'd28000, 10'd0, 32'd28010, 10'd0, 0, 0);
        // R1 extension bit 9 and low bits
        pwm_cur = 12'hFFA;
        sample(32'd32500, 10'h3FF, 32'd32500, 10'h000, 0, 0);
        // R4 non-positive reference delta gives no rate term
        pwm_cur = 12'h010;
        sample(32'd32500, 10'h3FF, 32'd32499, 10'h3F0, 0, 0);
        // R2 R3 error sequence
        sample(32'd37000, 10'd0, 32'd37000, 10'd0, 1, 0);
        sample(32'h0040_0000 | 32'd41500, 10'd0, 32'd41500, 10'd0, 0, 0);
        sample(32'd46000, 10'd0, 32'd46000, 10'd0, 1, 0);
        pwm_cur = 12'h020;
        sample(32'd50500, 10'd0, 32'd50500, 10'd3, 0, 0);
        sample(32'd55000, 10'd0, 32'h0080_0000 | 32'd55000, 10'd0, 0, 0);
        sample(32'd59500, 10'd0, 32'd59500, 10'd0, 1, 0);
        // R10 strobe while busy is ignored; R8 two small deltas in a row
        pwm_cur = 12'h7FE;
        sample(32'd64000, 10'd2, 32'd64000, 10'd0, 0, 1);
        sample(32'd68500, 10'd0, 32'd68500, 10'd1, 0, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule